// File: doc/BRIEF.md
# Two-Wire Block-Mode Configuration Slave

This block is the serial configuration port of a clock fan-out device. A system clock oversamples the two-wire bus lines (SCL and SDA). Each line passes through a synchronizer and a glitch filter. The block then detects START and STOP conditions and answers to the fixed 7-bit address 0x69. It serves block transfers that always begin at byte 0 and advance one byte at a time.

A write carries a command byte and a byte-count byte. The slave acknowledges both and then discards them. The data bytes that follow fill the configuration registers in ascending order. A read first returns the fixed byte-count value and then the registers from lowest to highest index.

The register bank appears on parallel outputs. The control register, index 6, also drives the per-pair output enables and the enhanced-drive select. SDA is driven open-drain: `sda_drive_low` high pulls the line low.

Top module: `smb_cfg_slave`

## Requirements
- R1: The address byte 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address byte gets no acknowledge, and the rest of that transfer is ignored.
- R2: In a write, the two bytes after the address are acknowledged and discarded. The following data bytes are acknowledged and stored into registers 0, 1, 2 and onward.
- R3: A read returns 0x09 first, then registers 0 upward, MSB first. An index past the last register reads as 0x00.
- R4: After reset, registers 0..5 hold 0x00 and register 6 holds 0x0F. So `pair_en` is all ones, `drive_boost` is 0, and SDA is released.
- R5: `pair_en[i]` follows register 6 bit i for i in 0..3, and `drive_boost` follows register 6 bit 5. Bits 4, 6 and 7 are stored and read back but drive no output.
- R6: A master NACK after a read byte ends the transfer. The slave releases SDA and ignores the bus until the next START.
- R7: A STOP or a repeated START returns the slave to address reception, and the byte index restarts at 0.
- R8: Data bytes written beyond the last register are acknowledged and discarded.
- R9: The slave changes its SDA drive only while SCL is low, and holds it for the whole SCL high phase.
- R10: Pulses on SCL shorter than FILT_LEN system clocks have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_flat | output | 8*NREG | Register bank, register i at bits 8*i+7..8*i |
| pair_en | output | NPAIR | Output-pair enables from register 6 |
| drive_boost | output | 1 | Enhanced-drive select from register 6 bit 5 |

## Verification
The bench uses the default parameters: FILT_LEN of 4, seven registers and a byte count of 9. It runs SCL with a quarter period of 20 system clocks, so the filter and synchronizer delay sits well inside every bus phase. The 2-cycle SCL glitches are injected below the filter length, which exercises R10 directly. A byte count larger than the register depth lets a full-count read walk past the last register.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NREG      = 7,
  parameter int         CTRL_IDX  = 6,
  parameter int         NPAIR     = 4,
  parameter int         BOOST_BIT = 5,
  parameter logic [7:0] CTRL_RST  = 8'h0F,
  parameter logic [7:0] COUNT_VAL = 8'h09,
  parameter int         FILT_LEN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_drive_low,
  output logic [8*NREG-1:0] cfg_flat,
  output logic [NPAIR-1:0]  pair_en,
  output logic              drive_boost
);
  localparam int FW = $clog2(FILT_LEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_WR, S_RD} st_t;

  logic [1:0] raw, flt;
  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic s1, s2, f;
    logic [FW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1; s2 <= 1'b1; f <= 1'b1; cnt <= '0;
      end else begin
        s1 <= raw[g];
        s2 <= s1;
        if (s2 == f) cnt <= '0;
        else if (cnt == FW'(FILT_LEN - 1)) begin
          f   <= s2;
          cnt <= '0;
        end else cnt <= cnt + FW'(1);
      end
    end
    assign flt[g] = f;
  end

  logic scl_q, sda_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_q <= 1'b1; sda_q <= 1'b1; end
    else begin scl_q <= flt[1]; sda_q <= flt[0]; end

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = flt[1] & ~scl_q;
  assign scl_fall = ~flt[1] & scl_q;
  assign start_c  = flt[1] & scl_q & sda_q & ~flt[0];
  assign stop_c   = flt[1] & scl_q & ~sda_q & flt[0];

  st_t        st;
  logic [3:0] bcnt;
  logic [7:0] sh, tx, bno, rd_byte;
  logic       rw;
  logic [7:0] regs [NREG];

  always_comb begin
    rd_byte = '0;
    if (bno == 8'd0) rd_byte = COUNT_VAL;
    else
      for (int i = 0; i < NREG; i++)
        if (int'(bno) == i + 1) rd_byte = regs[i];
  end

  logic we;
  assign we = scl_fall && bcnt == 4'd8 && st == S_WR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= (i == CTRL_IDX) ? CTRL_RST : 8'h00;
    end else if (we) begin
      for (int i = 0; i < NREG; i++)
        if (int'(bno) == i + 2) regs[i] <= sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; sh <= '0; tx <= '0; bno <= '0; rw <= 1'b0;
      sda_drive_low <= 1'b0;
    end else if (start_c) begin
      st <= S_ADDR; bcnt <= '0; bno <= '0; sda_drive_low <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; bcnt <= '0; sda_drive_low <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (bcnt < 4'd8) sh <= {sh[6:0], flt[0]};
        if (bcnt == 4'd8 && st == S_RD && flt[0]) st <= S_IDLE;
        if (bcnt <= 4'd8) bcnt <= bcnt + 4'd1;
      end else if (scl_fall) begin
        if (bcnt == 4'd8) begin
          case (st)
            S_ADDR: if (sh[7:1] == DEV_ADDR) begin
                      sda_drive_low <= 1'b1; rw <= sh[0]; bno <= '0;
                    end else st <= S_IDLE;
            S_WR:   sda_drive_low <= 1'b1;
            default: sda_drive_low <= 1'b0;
          endcase
        end else if (bcnt == 4'd9) begin
          bcnt <= '0;
          sda_drive_low <= 1'b0;
          if ((st == S_ADDR && rw) || st == S_RD) begin
            st <= S_RD;
            tx <= {rd_byte[6:0], 1'b0};
            sda_drive_low <= ~rd_byte[7];
            if (bno != 8'hFF) bno <= bno + 8'd1;
          end else if (st == S_ADDR) st <= S_WR;
          else if (bno != 8'hFF) bno <= bno + 8'd1;
        end else if (st == S_RD && bcnt != 4'd0) begin
          sda_drive_low <= ~tx[7];
          tx <= {tx[6:0], 1'b0};
        end
      end
    end else begin
      sda_drive_low <= 1'b0;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_flat
    assign cfg_flat[8*i +: 8] = regs[i];
  end
  assign pair_en     = regs[CTRL_IDX][NPAIR-1:0];
  assign drive_boost = regs[CTRL_IDX][BOOST_BIT];
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int NREG  = 7,
  parameter int NPAIR = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_in,
  input logic              sda_drive_low,
  input logic [8*NREG-1:0] cfg_flat,
  input logic [NPAIR-1:0]  pair_en
);
  // R9: drive changes only in the SCL low phase
  a_r9_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_in);
  // R9: a low drive is held while SCL is high
  a_r9_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drive_low && scl_in) |=> sda_drive_low);
  // R2: a register update coincides with the slave starting its acknowledge
  a_r2_write_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_flat) |-> $rose(sda_drive_low));
  // R5: enables change only while SCL is low
  a_r5_pair_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pair_en) |-> !scl_in);
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG), .NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_drive_low(sda_drive_low),
  .cfg_flat(cfg_flat), .pair_en(pair_en)
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;
  localparam int T = 20;
  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, glitch = 1'b0;
  logic drv;
  logic [55:0] cfg;
  logic [3:0] pair_en;
  logic boost;
  wire sda_bus = m_sda & ~drv;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  smb_cfg_slave u_smb_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .sda_drive_low(drv), .cfg_flat(cfg), .pair_en(pair_en), .drive_boost(boost));

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic m_start;
    m_sda = 1'b1; w(T); m_scl = 1'b1; w(T); m_sda = 1'b0; w(T); m_scl = 1'b0; w(T);
  endtask

  task automatic m_stop;
    m_sda = 1'b0; w(T); m_scl = 1'b1; w(T); m_sda = 1'b1; w(T);
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      if (glitch) begin
        w(8); m_scl = 1'b1; w(2); m_scl = 1'b0; w(T - 10);
      end else w(T);
      m_scl = 1'b1; w(2 * T); m_scl = 1'b0; w(T);
    end
    m_sda = 1'b1; w(T); m_scl = 1'b1; w(T); ack = ~sda_bus; w(T); m_scl = 1'b0; w(T);
  endtask

  task automatic m_rbyte(input logic ack, output logic [7:0] b);
    logic a, c;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(T); m_scl = 1'b1; w(2); a = sda_bus; w(2 * T - 4); c = sda_bus; w(2);
      m_scl = 1'b0; w(T - T);
      chk("R9 hold during SCL high", {63'd0, c}, {63'd0, a});
      b[i] = a;
    end
    w(T); m_sda = ~ack; m_scl = 1'b1; w(2 * T); m_scl = 1'b0; w(T); m_sda = 1'b1;
  endtask

  task automatic wr_block(input logic [7:0] d [], input string req);
    logic ack;
    m_start;
    m_wbyte(8'hD2, ack); chk({req, " addr ack"}, {63'd0, ack}, 64'd1);
    m_wbyte(8'h5A, ack); chk("R2 command ack", {63'd0, ack}, 64'd1);
    m_wbyte(8'h33, ack); chk("R2 count ack", {63'd0, ack}, 64'd1);
    foreach (d[i]) begin
      m_wbyte(d[i], ack); chk({req, " data ack"}, {63'd0, ack}, 64'd1);
    end
    m_stop;
  endtask

  task automatic t_reset;
    chk("R4 reset cfg", {8'd0, cfg}, {8'd0, 8'h0F, 48'd0});
    chk("R4 reset pair_en", {60'd0, pair_en}, 64'hF);
    chk("R4 reset boost", {63'd0, boost}, 64'd0);
    chk("R4 reset sda", {63'd0, drv}, 64'd0);
  endtask

  task automatic t_write_block;
    wr_block('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h2A}, "R2");
    chk("R2 stored bytes", {8'd0, cfg}, {8'd0, 56'h2A665544332211});
    chk("R5 pair_en from bits 0-3", {60'd0, pair_en}, 64'hA);
    chk("R5 boost from bit 5", {63'd0, boost}, 64'd1);
  endtask

  task automatic t_wrong_addr;
    logic ack;
    m_start;
    m_wbyte(8'hA4, ack); chk("R1 foreign address no ack", {63'd0, ack}, 64'd0);
    m_wbyte(8'h5A, ack); m_wbyte(8'h00, ack); m_wbyte(8'h99, ack);
    chk("R1 ignored byte no ack", {63'd0, ack}, 64'd0);
    m_stop;
    chk("R1 cfg untouched", {8'd0, cfg}, {8'd0, 56'h2A665544332211});
  endtask

  task automatic t_read_block;
    logic ack;
    logic [7:0] b;
    logic [7:0] exp [9] = '{8'h09, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h2A, 8'h00};
    m_start;
    m_wbyte(8'hD3, ack); chk("R1 read addr ack", {63'd0, ack}, 64'd1);
    for (int i = 0; i < 9; i++) begin
      m_rbyte(i != 8, b);
      chk("R3 read byte", {56'd0, b}, {56'd0, exp[i]});
    end
    m_stop;
  endtask

  task automatic t_reserved;
    logic ack;
    logic [7:0] b;
    wr_block('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'hD0}, "R5");
    chk("R5 reserved bits leave pair_en", {60'd0, pair_en}, 64'h0);
    chk("R5 reserved bits leave boost", {63'd0, boost}, 64'd0);
    m_start; m_wbyte(8'hD3, ack);
    for (int i = 0; i < 8; i++) m_rbyte(i != 7, b);
    m_stop;
    chk("R5 reserved bits read back", {56'd0, b}, 64'hD0);
  endtask

  task automatic t_past_last;
    wr_block('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'hEE, 8'hEF}, "R8");
    chk("R8 excess bytes discarded", {8'd0, cfg}, {8'd0, 56'h07060504030201});
  endtask

  task automatic t_nack_abort;
    logic ack;
    logic [7:0] b;
    m_start; m_wbyte(8'hD3, ack);
    m_rbyte(1'b0, b); chk("R6 count byte", {56'd0, b}, 64'h09);
    chk("R6 released after nack", {63'd0, drv}, 64'd0);
    m_rbyte(1'b0, b); chk("R6 bus idle after nack", {56'd0, b}, 64'hFF);
    m_stop;
    m_start; m_wbyte(8'hD3, ack);
    m_rbyte(1'b0, b); chk("R7 index restarts", {56'd0, b}, 64'h09);
    m_stop;
  endtask

  task automatic t_rep_start;
    logic ack;
    logic [7:0] b;
    m_start; m_wbyte(8'hD2, ack); m_wbyte(8'h00, ack); m_wbyte(8'h01, ack);
    m_wbyte(8'h77, ack);
    m_start;
    m_wbyte(8'hD3, ack); chk("R7 addr after repeated start", {63'd0, ack}, 64'd1);
    m_rbyte(1'b1, b); chk("R7 count first", {56'd0, b}, 64'h09);
    m_rbyte(1'b1, b); chk("R7 reg0 written", {56'd0, b}, 64'h77);
    m_rbyte(1'b0, b); chk("R7 reg1 kept", {56'd0, b}, 64'h02);
    m_stop;
  endtask

  task automatic t_stop_mid;
    logic ack;
    m_start; m_wbyte(8'hD2, ack); m_wbyte(8'h00, ack); m_wbyte(8'h01, ack);
    m_wbyte(8'h88, ack); m_stop;
    m_start; m_wbyte(8'hD2, ack); m_wbyte(8'h00, ack); m_wbyte(8'h01, ack);
    m_wbyte(8'h99, ack); m_stop;
    chk("R7 stop restarts at reg0", {48'd0, cfg[15:0]}, 64'h0299);
  endtask

  task automatic t_glitch;
    glitch = 1'b1;
    wr_block('{8'h5C, 8'hA3}, "R10");
    glitch = 1'b0;
    chk("R10 glitches ignored", {48'd0, cfg[15:0]}, 64'hA35C);
  endtask

  initial begin
    w(10); rst_n = 1'b1; w(5);
    t_reset;
    t_write_block;
    t_wrong_addr;
    t_read_block;
    t_reserved;
    t_past_last;
    t_nack_abort;
    t_rep_start;
    t_stop_mid;
    t_glitch;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule